// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin Ownership Overrides

This block is an eight-pin bidirectional I/O port. Software sets it up through a small register bus. There is a direction register (a 1 bit makes the pin an input), an output latch and a configuration register. Reads return either the latch contents or the pin levels after synchronization. Each pin produces an output value, an output enable, a weak pull-up enable and an input buffer type flag, all going to the pad models.

Several sources can take over a pin. In order of priority they are an external multiplexed address/data bus, a parallel slave port mode, a serial peripheral on pins 4 to 6, and plain GPIO. The external bus and the slave port take all eight pins, and each sets their direction from its own drive-enable input. The serial peripheral can be switched to open-drain drive. Pull-ups turn off on any pin whose driver is enabled, and one configuration bit turns all of them off. Pin levels also leave the block after synchronization, for use by the peripherals.

Top module: `gpio_ovr_port`

## Requirements
- R1: Register map on `busAddr`: 0 = pin port, 1 = output latch, 2 = direction, 3 = configuration. The configuration bits are: bit0 pull-up global disable, bit1 serial open-drain, bit2 external bus enable, bit3 parallel slave port mode. Registers update on the clock edge where `busWe` is high.
- R2: After reset the direction register reads 0xFF, the latch reads 0x00 and the configuration reads 0x1. Every `padOe` bit and every `padPullUp` bit is then 0.
- R3: `padPullUp[i]` is 1 exactly when configuration bit0 is 0 and `padOe[i]` is 0.
- R4: A write to address 0 or to address 1 loads the output latch. A read of address 1 returns the latch. Reads of addresses 2 and 3 return the direction and configuration values, with the upper configuration bits read as zero.
- R5: A read of address 0 returns `padIn` as it was two clock edges earlier. `syncIn` carries the same value.
- R6: In plain GPIO ownership, a direction bit of 0 gives `padOe[i]`=1 and `padOut[i]` = latch bit. A direction bit of 1 gives `padOe[i]`=0.
- R7: With external bus enable set, every pin has `padOut` = `extBusOut` and `padOe` = `extBusDrive`, whatever the direction register holds.
- R8: With slave port mode set and the external bus disabled, every pin has `padOut` = `pspOut` and `padOe` = `pspDrive`.
- R9: `padTtl[i]` is 1 for all pins while slave port mode or external bus enable is set. Otherwise it is 0 (Schmitt trigger).
- R10: If neither full-port owner is active, pin 4+k with `serEn[k]`=1 follows the serial peripheral. In push-pull mode `padOut` = `serOut[k]` and `padOe` = `serOe[k]`. In open-drain mode `padOut` = 0 and `padOe` = `serOe[k]` AND NOT `serOut[k]`.
- R11: Ownership priority is external bus, then slave port, then serial peripheral, then GPIO.
- R12: Writing 0xCF to the direction register makes pins 5 and 4 outputs and pins 7, 6 and 3 to 0 inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` |
| padIn | input | 8 | Pin levels from the pads |
| extBusOut | input | 8 | External bus address/data out |
| extBusDrive | input | 1 | External bus drive enable |
| pspOut | input | 8 | Slave port data out |
| pspDrive | input | 1 | Slave port drive enable |
| serEn | input | 3 | Serial peripheral owns pins 4..6 |
| serOut | input | 3 | Serial peripheral output values |
| serOe | input | 3 | Serial peripheral output enables |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| padPullUp | output | 8 | Weak pull-up enables |
| padTtl | output | 8 | 1 = TTL input buffer, 0 = Schmitt trigger |
| syncIn | output | 8 | Synchronized pin levels |

## Verification
Two things can happen in the same cycle: a software write to the latch, direction or configuration register, and a change of pin owner driven by `serEn` or the mode bits. Random steps drive a register write and new override inputs together on one edge. After the edge, the pad outputs are compared with a bench model that applies the priority rules to the shadow registers as they stand after that write. A directed case also writes the latch while the serial peripheral holds a pin. The written value must appear only once the peripheral releases the pin.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int PORT_W = 8;
  localparam int CFG_W  = 4;

  localparam logic [1:0] ADDR_PORT = 2'd0;
  localparam logic [1:0] ADDR_LAT  = 2'd1;
  localparam logic [1:0] ADDR_DIR  = 2'd2;
  localparam logic [1:0] ADDR_CFG  = 2'd3;

  typedef struct packed {
    logic              latWr;
    logic [PORT_W-1:0] wdata;
  } portStrobe_t;

  typedef struct packed {
    logic [PORT_W-1:0] dir;
    logic              pspEn;
    logic              extEn;
    logic              odEn;
    logic              pullDis;
  } portCfg_t;
endpackage

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl
  import gpio_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic [PORT_W-1:0] busWdata,
  output portStrobe_t       strobe,
  output portCfg_t          cfg
);
  logic dirWr, cfgWr;

  always_comb begin
    strobe.latWr = busWe && (busAddr == ADDR_PORT || busAddr == ADDR_LAT);
    strobe.wdata = busWdata;
    dirWr = busWe && (busAddr == ADDR_DIR);
    cfgWr = busWe && (busAddr == ADDR_CFG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.dir     <= '1;
      cfg.pullDis <= 1'b1;
      cfg.odEn    <= 1'b0;
      cfg.extEn   <= 1'b0;
      cfg.pspEn   <= 1'b0;
    end else begin
      if (dirWr) cfg.dir <= busWdata;
      if (cfgWr) {cfg.pspEn, cfg.extEn, cfg.odEn, cfg.pullDis} <= busWdata[CFG_W-1:0];
    end
  end

  // R1: a direction write lands on the next edge
  p_dir_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWe && busAddr == ADDR_DIR) |-> cfg.dir == $past(busWdata));

  // R11: the external bus keeps its configuration until it is written again
  p_ext_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWe && busAddr == ADDR_CFG) |-> $stable(cfg.extEn));
endmodule

// File: rtl/gpio_ovr_datapath.sv
module gpio_ovr_datapath
  import gpio_ovr_pkg::*;
#(
  parameter int SER_BASE = 4,
  parameter int SER_N    = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  portCfg_t          cfg,
  input  logic [1:0]        busAddr,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] padIn,
  input  logic [PORT_W-1:0] extBusOut,
  input  logic              extBusDrive,
  input  logic [PORT_W-1:0] pspOut,
  input  logic              pspDrive,
  input  logic [SER_N-1:0]  serEn,
  input  logic [SER_N-1:0]  serOut,
  input  logic [SER_N-1:0]  serOe,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padPullUp,
  output logic [PORT_W-1:0] padTtl,
  output logic [PORT_W-1:0] syncIn
);
  logic [PORT_W-1:0] latQ, syncA, syncB;
  logic [1:0]        warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ  <= '0;
      syncA <= '0;
      syncB <= '0;
      warm  <= '0;
    end else begin
      if (strobe.latWr) latQ <= strobe.wdata;
      syncA <= padIn;
      syncB <= syncA;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  assign syncIn = syncB;

  always_comb begin
    unique case (busAddr)
      ADDR_PORT: busRdata = syncB;
      ADDR_LAT:  busRdata = latQ;
      ADDR_DIR:  busRdata = cfg.dir;
      default:   busRdata = {{(PORT_W-CFG_W){1'b0}}, cfg.pspEn, cfg.extEn, cfg.odEn, cfg.pullDis};
    endcase
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic gpOut, gpOe;
    if (i >= SER_BASE && i < SER_BASE + SER_N) begin : g_ser
      localparam int K = i - SER_BASE;
      always_comb begin
        if (serEn[K]) begin
          gpOut = cfg.odEn ? 1'b0 : serOut[K];
          gpOe  = cfg.odEn ? (serOe[K] & ~serOut[K]) : serOe[K];
        end else begin
          gpOut = latQ[i];
          gpOe  = ~cfg.dir[i];
        end
      end
    end else begin : g_gp
      assign gpOut = latQ[i];
      assign gpOe  = ~cfg.dir[i];
    end

    always_comb begin
      if (cfg.extEn) begin
        padOut[i] = extBusOut[i];
        padOe[i]  = extBusDrive;
      end else if (cfg.pspEn) begin
        padOut[i] = pspOut[i];
        padOe[i]  = pspDrive;
      end else begin
        padOut[i] = gpOut;
        padOe[i]  = gpOe;
      end
      padPullUp[i] = ~cfg.pullDis & ~padOe[i];
      padTtl[i]    = cfg.pspEn | cfg.extEn;
    end
  end

  // R4: the latch takes the data of a port or latch write
  p_latch_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.latWr) |-> latQ == $past(strobe.wdata));

  // R5: the synchronized input lags the pads by two edges
  p_sync_lag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2) |-> syncIn == $past(padIn, 2));

  // R3: the global disable silences every pull-up
  p_pull_global_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfg.pullDis |-> padPullUp == '0);

  // R10: in open-drain mode a serial pin never drives high
  p_od_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.odEn && !cfg.extEn && !cfg.pspEn) |->
      (padOut[SER_BASE +: SER_N] & padOe[SER_BASE +: SER_N] & serEn) == '0);

  // R7: the external bus overrides the direction register
  p_ext_own_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfg.extEn |-> padOut == extBusOut);
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int SER_BASE = 4,
  parameter int SER_N    = 3
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic [PORT_W-1:0] padIn,
  input  logic [PORT_W-1:0] extBusOut,
  input  logic              extBusDrive,
  input  logic [PORT_W-1:0] pspOut,
  input  logic              pspDrive,
  input  logic [SER_N-1:0]  serEn,
  input  logic [SER_N-1:0]  serOut,
  input  logic [SER_N-1:0]  serOe,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padPullUp,
  output logic [PORT_W-1:0] padTtl,
  output logic [PORT_W-1:0] syncIn
);
  portStrobe_t strobe;
  portCfg_t    cfg;

  gpio_ovr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strobe(strobe), .cfg(cfg)
  );

  gpio_ovr_datapath #(.SER_BASE(SER_BASE), .SER_N(SER_N)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg), .busAddr(busAddr),
    .busRdata(busRdata), .padIn(padIn), .extBusOut(extBusOut),
    .extBusDrive(extBusDrive), .pspOut(pspOut), .pspDrive(pspDrive),
    .serEn(serEn), .serOut(serOut), .serOe(serOe), .padOut(padOut),
    .padOe(padOe), .padPullUp(padPullUp), .padTtl(padTtl), .syncIn(syncIn)
  );
endmodule

// File: tb/gpio_ovr_port_tb.sv
`timescale 1ns/1ps
module gpio_ovr_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic [7:0] padIn = '0, extBusOut = '0, pspOut = '0;
  logic       extBusDrive = 1'b0, pspDrive = 1'b0;
  logic [2:0] serEn = '0, serOut = '0, serOe = '0;
  logic [7:0] padOut, padOe, padPullUp, padTtl, syncIn;

  int checks = 0, errors = 0;
  logic [7:0] mLat = 8'h00, mDir = 8'hFF;
  logic [3:0] mCfg = 4'h1;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_ovr_port dut_i (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expPins();
    logic [7:0] eo, ee;
    for (int i = 0; i < 8; i++) begin
      if (mCfg[2]) begin eo[i] = extBusOut[i]; ee[i] = extBusDrive; end
      else if (mCfg[3]) begin eo[i] = pspOut[i]; ee[i] = pspDrive; end
      else if (i >= 4 && i <= 6 && serEn[i-4]) begin
        eo[i] = mCfg[1] ? 1'b0 : serOut[i-4];
        ee[i] = mCfg[1] ? (serOe[i-4] & ~serOut[i-4]) : serOe[i-4];
      end else begin eo[i] = mLat[i]; ee[i] = ~mDir[i]; end
    end
    return {eo, ee};
  endfunction

  task automatic checkPins(string tag);
    logic [15:0] e = expPins();
    chk({tag, " R6/R11 padOut"}, padOut, e[15:8]);
    chk({tag, " R6/R11 padOe"}, padOe, e[7:0]);
    chk({tag, " R3 pullup"}, padPullUp, mCfg[0] ? 8'h00 : ~e[7:0]);
    chk({tag, " R9 ttl"}, padTtl, (mCfg[2] | mCfg[3]) ? 8'hFF : 8'h00);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
    case (a)
      2'd0, 2'd1: mLat = d;
      2'd2: mDir = d;
      default: mCfg = d[3:0];
    endcase
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #0.5 d = busRdata;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2 reset state
    rd(2'd2, r); chk("R2 dir reset", r, 8'hFF);
    rd(2'd1, r); chk("R2 latch reset", r, 8'h00);
    rd(2'd3, r); chk("R2 cfg reset", r, 8'h01);
    chk("R2 padOe reset", padOe, 8'h00);
    chk("R2 pullup reset", padPullUp, 8'h00);
    // R12 direction 0xCF
    wr(2'd1, 8'hA5); wr(2'd2, 8'hCF);
    chk("R12 oe for 0xCF", padOe, 8'h30);
    chk("R12 out on 5:4", padOut & 8'h30, 8'h20);
    // R4 port address also loads latch
    wr(2'd0, 8'h5A); rd(2'd1, r); chk("R4 latch via port addr", r, 8'h5A);
    // R3 pullups when enabled
    wr(2'd3, 4'h0); checkPins("R3 pull on");
    // R5 two-edge sync
    @(negedge clk); padIn = 8'h3C; busAddr = 2'd0;
    @(negedge clk); #0.5 chk("R5 after one edge", busRdata, 8'h00);
    @(negedge clk); #0.5 chk("R5 after two edges", busRdata, 8'h3C);
    chk("R5 syncIn", syncIn, 8'h3C);
    // R10 open drain, concurrent latch write while serial owns pin 5
    @(negedge clk); serEn = 3'b010; serOut = 3'b010; serOe = 3'b010;
    wr(2'd3, 4'h2); wr(2'd1, 8'h20); checkPins("R10 od high floats");
    chk("R10 od pin5 oe", padOe[5], 1'b0);
    @(negedge clk); serEn = 3'b000; #0.5 chk("R10 latch after release", padOut[5], 1'b1);
    // R7/R8/R11 priority
    @(negedge clk); extBusOut = 8'h96; extBusDrive = 1'b1; pspOut = 8'h11; pspDrive = 1'b0;
    wr(2'd3, 4'hC); checkPins("R7 ext over psp");
    wr(2'd3, 4'h8); checkPins("R8 psp");
    rd(2'd3, r); chk("R4 cfg readback", r, 8'h08);
    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [1:0] a = 2'($urandom_range(3, 0));
      logic [7:0] d = 8'($urandom);
      @(negedge clk);
      extBusOut = 8'($urandom); extBusDrive = 1'($urandom);
      pspOut = 8'($urandom); pspDrive = 1'($urandom);
      serEn = 3'($urandom); serOut = 3'($urandom); serOe = 3'($urandom);
      padIn = 8'($urandom);
      if (a == 2'd3 && $urandom_range(3, 0) != 0) d[3:2] = 2'b00;
      busAddr = a; busWe = 1'b1; busWdata = d;
      @(negedge clk);
      busWe = 1'b0;
      case (a)
        2'd0, 2'd1: mLat = d;
        2'd2: mDir = d;
        default: mCfg = d[3:0];
      endcase
      checkPins("R11 random");
      busAddr = 2'($urandom_range(3, 1));
      #0.5;
      chk("R4 random readback", busRdata,
          busAddr == 2'd1 ? mLat : busAddr == 2'd2 ? mDir : {4'h0, mCfg});
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule